// File: doc/BRIEF.md
# Next-PC Steering Unit

This unit chooses the program counter for the instruction after the current one in a 16-bit processor. The fetch stage has already incremented the PC. The unit receives that incremented value, the instruction word, the current sign flags (negative, zero, positive) and one register value. From these it resolves conditional branches, register jumps, PC-relative and register-based subroutine calls, and trap entry. For a call or a trap it also produces a link value, which the register file writes so that the called routine can return.

A trap target lives in a vector table outside the unit. In the cycle the trap is accepted, the unit drives a read request with the vector index. The table answers one clock later with registered read data. Because of this, a trap result appears one cycle later than every other result. For that one cycle `busy` is high and new instructions are refused.

Every other instruction is accepted in one cycle. Its result is registered and appears after the next rising clock edge, with `npc_valid` high for that single cycle.

Top module: `pc_steer`

## Requirements
- R1: While reset is asserted, and until the first instruction is accepted, `npc_valid`, `link_we` and `busy` are 0 and `next_pc` is 0.
- R2: Opcode 0000 in bits [15:12] is a conditional branch. Bits [11:9] are a mask in the order negative, zero, positive, and `flags` uses the same order. If any mask bit matches a set flag, `next_pc` = `pc_inc` + sign-extended bits [8:0]. Otherwise `next_pc` = `pc_inc`. Neither case writes a link.
- R3: A branch with mask 000 never redirects, whatever the flags are. A branch with mask 111 always redirects when exactly one flag is set.
- R4: Opcode 1100 is a jump. `base_idx` equals bits [8:6], `next_pc` equals `base_val`, and `link_we` stays 0.
- R5: Opcode 0100 with bit 11 set is a PC-relative call. `next_pc` = `pc_inc` + sign-extended bits [10:0], `link_we` is 1 and `link_val` = `pc_inc`.
- R6: Opcode 0100 with bit 11 clear is a register call. `next_pc` = `base_val` (register index in bits [8:6]), `link_we` is 1 and `link_val` = `pc_inc`.
- R7: Opcode 1111 is a trap. In the accept cycle `vec_rd` is 1 and `vec_addr` = bits [7:0]. Two rising edges after acceptance, `next_pc` equals the table word and `link_val` equals the incremented PC of the trap, with `link_we` 1.
- R8: For the one cycle between trap acceptance and its result, `busy` is 1. An `instr_valid` in that cycle is ignored and produces no result.
- R9: Any other opcode (for example 0001) gives `next_pc` = `pc_inc` and `link_we` = 0.
- R10: For every non-trap instruction, the result appears after the first rising edge following acceptance. `npc_valid` is high for one cycle for each accepted instruction, including back-to-back ones.
- R11: All target additions wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the instruction after this one |
| flags | input | 3 | Sign flags {negative, zero, positive} |
| base_idx | output | 3 | Register index for jumps and register calls |
| base_val | input | 16 | Register file value at `base_idx` |
| vec_rd | output | 1 | Vector table read request |
| vec_addr | output | 8 | Vector table index |
| vec_data | input | 16 | Table word, registered one cycle after `vec_rd` |
| busy | output | 1 | Trap waiting for table data; input refused |
| npc_valid | output | 1 | `next_pc` is valid this cycle |
| next_pc | output | 16 | Resolved next program counter |
| link_we | output | 1 | `link_val` must be written to the link register |
| link_val | output | 16 | Return address |

## Verification
The only internal state is the trap wait state and the saved return address. A wait state left set would show one cycle after the trap: `busy` would stay high and the next instruction would get no `npc_valid`. A wrong saved return address shows on `link_val` two edges after the trap. Decode or flag-matching errors are not stored anywhere. They appear on `next_pc` and `link_we` one edge after the instruction, so each directed case checks at that point. The ignored instruction during `busy` is checked by looking for a missing `npc_valid` in the following cycle.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  localparam int XLEN = 16;
  localparam int VEC_W = 8;
  localparam int FLG_W = 3;
  localparam int REG_IDX_W = 3;

  typedef enum logic [2:0] {
    K_BRANCH,
    K_JUMP,
    K_CALL_REL,
    K_CALL_REG,
    K_TRAP,
    K_SEQ
  } ctl_kind_e;

  localparam logic [3:0] OP_BRANCH = 4'b0000;
  localparam logic [3:0] OP_JUMP   = 4'b1100;
  localparam logic [3:0] OP_CALL   = 4'b0100;
  localparam logic [3:0] OP_TRAP   = 4'b1111;

  // sign extension of the 9-bit branch displacement
  function automatic logic [XLEN-1:0] sext_d9(input logic [8:0] f);
    return {{(XLEN-9){f[8]}}, f};
  endfunction

  // sign extension of the 11-bit call displacement
  function automatic logic [XLEN-1:0] sext_d11(input logic [10:0] f);
    return {{(XLEN-11){f[10]}}, f};
  endfunction

  // modular add used by every relative target
  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] base,
                                                 input logic [XLEN-1:0] disp);
    return base + disp;
  endfunction

  // a branch redirects when any selected flag is currently set
  function automatic logic mask_hit(input logic [FLG_W-1:0] mask,
                                    input logic [FLG_W-1:0] flg);
    return |(mask & flg);
  endfunction
endpackage

// File: rtl/pc_steer_decode.sv
module pc_steer_decode
  import pc_steer_pkg::*;
(
  input  logic [XLEN-1:0]      instr,
  output ctl_kind_e            kind,
  output logic [FLG_W-1:0]     br_mask,
  output logic [8:0]           disp9,
  output logic [10:0]          disp11,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [VEC_W-1:0]     vec_idx
);
  logic [3:0] opc;
  assign opc     = instr[XLEN-1 -: 4];
  assign br_mask = instr[11:9];
  assign disp9   = instr[8:0];
  assign disp11  = instr[10:0];
  assign reg_idx = instr[8:6];
  assign vec_idx = instr[VEC_W-1:0];

  always_comb begin
    unique case (opc)
      OP_BRANCH: kind = K_BRANCH;
      OP_JUMP:   kind = K_JUMP;
      OP_CALL:   kind = instr[11] ? K_CALL_REL : K_CALL_REG;
      OP_TRAP:   kind = K_TRAP;
      default:   kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_steer_target.sv
module pc_steer_target
  import pc_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_kind_e        kind,
  input  logic [FLG_W-1:0] br_mask,
  input  logic [8:0]       disp9,
  input  logic [10:0]      disp11,
  input  logic [FLG_W-1:0] flags,
  input  logic [XLEN-1:0]  pc_inc,
  input  logic [XLEN-1:0]  base_val,
  output logic [XLEN-1:0]  tgt,
  output logic             br_taken,
  output logic             wants_link
);
  logic [XLEN-1:0] br_dest;
  logic [XLEN-1:0] call_dest;

  assign br_taken   = (kind == K_BRANCH) && mask_hit(br_mask, flags);
  assign br_dest    = rel_target(pc_inc, sext_d9(disp9));
  assign call_dest  = rel_target(pc_inc, sext_d11(disp11));
  assign wants_link = (kind == K_CALL_REL) || (kind == K_CALL_REG) || (kind == K_TRAP);

  always_comb begin
    unique case (kind)
      K_BRANCH:   tgt = br_taken ? br_dest : pc_inc;
      K_JUMP:     tgt = base_val;
      K_CALL_REL: tgt = call_dest;
      K_CALL_REG: tgt = base_val;
      default:    tgt = pc_inc;
    endcase
  end

  // R3
  br_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRANCH && br_mask == 3'b000) |-> (tgt == pc_inc));

  // R3
  br_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRANCH && br_mask == 3'b111 && $onehot(flags)) |-> br_taken);

  // R9
  seq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SEQ) |-> (tgt == pc_inc && !wants_link));
endmodule

// File: rtl/pc_steer_seq.sv
module pc_steer_seq
  import pc_steer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            is_trap,
  input  logic            wants_link,
  input  logic [XLEN-1:0] tgt,
  input  logic [XLEN-1:0] pc_inc,
  input  logic [XLEN-1:0] vec_data,
  output logic            waiting,
  output logic            npc_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_val
);
  typedef enum logic {S_RUN, S_VWAIT} seq_st_e;
  seq_st_e st;
  logic [XLEN-1:0] held_ret;

  assign waiting = (st == S_VWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      held_ret  <= '0;
      npc_valid <= 1'b0;
      next_pc   <= '0;
      link_we   <= 1'b0;
      link_val  <= '0;
    end else if (st == S_VWAIT) begin
      st        <= S_RUN;
      npc_valid <= 1'b1;
      next_pc   <= vec_data;
      link_we   <= 1'b1;
      link_val  <= held_ret;
    end else if (accept && is_trap) begin
      st        <= S_VWAIT;
      held_ret  <= pc_inc;
      npc_valid <= 1'b0;
      link_we   <= 1'b0;
    end else if (accept) begin
      npc_valid <= 1'b1;
      next_pc   <= tgt;
      link_we   <= wants_link;
      link_val  <= pc_inc;
    end else begin
      npc_valid <= 1'b0;
      link_we   <= 1'b0;
    end
  end

  // R8
  trap_wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> !waiting);

  // R10
  npc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npc_valid |-> ($past(accept && !is_trap) || $past(waiting)));

  // R7
  trap_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> (npc_valid && link_we));
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [XLEN-1:0]      instr,
  input  logic [XLEN-1:0]      pc_inc,
  input  logic [FLG_W-1:0]     flags,
  output logic [REG_IDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]      base_val,
  output logic                 vec_rd,
  output logic [VEC_W-1:0]     vec_addr,
  input  logic [XLEN-1:0]      vec_data,
  output logic                 busy,
  output logic                 npc_valid,
  output logic [XLEN-1:0]      next_pc,
  output logic                 link_we,
  output logic [XLEN-1:0]      link_val
);
  ctl_kind_e        kind;
  logic [FLG_W-1:0] br_mask;
  logic [8:0]       disp9;
  logic [10:0]      disp11;
  logic [VEC_W-1:0] vec_idx;
  logic [XLEN-1:0]  tgt;
  logic             br_taken;
  logic             wants_link;
  logic             accept;
  logic             is_trap;

  pc_steer_decode u_dec (
    .instr(instr), .kind(kind), .br_mask(br_mask), .disp9(disp9),
    .disp11(disp11), .reg_idx(base_idx), .vec_idx(vec_idx)
  );

  pc_steer_target u_tgt (
    .clk(clk), .rst_n(rst_n), .kind(kind), .br_mask(br_mask), .disp9(disp9),
    .disp11(disp11), .flags(flags), .pc_inc(pc_inc), .base_val(base_val),
    .tgt(tgt), .br_taken(br_taken), .wants_link(wants_link)
  );

  assign accept   = instr_valid && !busy;
  assign is_trap  = (kind == K_TRAP);
  assign vec_rd   = accept && is_trap;
  assign vec_addr = vec_idx;

  pc_steer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_trap(is_trap),
    .wants_link(wants_link), .tgt(tgt), .pc_inc(pc_inc), .vec_data(vec_data),
    .waiting(busy), .npc_valid(npc_valid), .next_pc(next_pc),
    .link_we(link_we), .link_val(link_val)
  );

  // R4
  jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(accept) && $past(kind) == K_JUMP) |->
      (next_pc == $past(base_val) && !link_we));

  // R7
  trap_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> (busy && !npc_valid));

  // R5
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(accept) && ($past(kind) == K_CALL_REL || $past(kind) == K_CALL_REG))
      |-> (link_we && link_val == $past(pc_inc)));

  // R2
  br_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(accept) && $past(kind) == K_BRANCH) |-> (npc_valid && !link_we));
endmodule

// File: tb/pc_steer_bench.sv
module pc_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_inc = '0;
  logic [2:0]  flags = '0;
  logic [2:0]  base_idx;
  logic [15:0] base_val = '0;
  logic        vec_rd;
  logic [7:0]  vec_addr;
  logic [15:0] vec_data;
  logic        busy, npc_valid, link_we;
  logic [15:0] next_pc, link_val;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pc_steer u_pc_steer (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc_inc(pc_inc), .flags(flags), .base_idx(base_idx), .base_val(base_val),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data), .busy(busy),
    .npc_valid(npc_valid), .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  function automatic logic [15:0] table_word(input logic [7:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk) if (vec_rd) vec_data <= table_word(vec_addr);

  function automatic logic [15:0] add_off(input logic [15:0] pc, input int off);
    int s;
    s = int'(pc) + off;
    return s[15:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one instruction for one cycle; return after the accepting edge
  task automatic send(input logic [15:0] i, input logic [15:0] pc,
                      input logic [2:0] f, input logic [15:0] b);
    @(negedge clk);
    instr = i; pc_inc = pc; flags = f; base_val = b; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 npc_valid", {15'd0, npc_valid}, 16'd0);
    chk("R1 link_we", {15'd0, link_we}, 16'd0);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 next_pc", next_pc, 16'd0);
  endtask

  task automatic t_branch(input logic [2:0] m, input logic [2:0] f,
                          input logic [8:0] d, input logic [15:0] pc,
                          input bit tk, input string req);
    int off;
    off = d[8] ? int'(d) - 512 : int'(d);
    send({4'b0000, m, d}, pc, f, 16'hDEAD);
    chk({req, " npc_valid"}, {15'd0, npc_valid}, 16'd1);
    chk({req, " target"}, next_pc, tk ? add_off(pc, off) : pc);
    chk({req, " no link"}, {15'd0, link_we}, 16'd0);
  endtask

  task automatic t_jump;
    send({4'b1100, 3'b000, 3'd5, 6'd0}, 16'h3000, 3'b010, 16'h4321);
    chk("R4 target", next_pc, 16'h4321);
    chk("R4 no link", {15'd0, link_we}, 16'd0);
  endtask

  task automatic t_base_idx;
    @(negedge clk);
    instr = {4'b1100, 3'b000, 3'd6, 6'd0};
    #1 chk("R4 base_idx", {13'd0, base_idx}, 16'd6);
    instr = {4'b0100, 1'b0, 2'b00, 3'd3, 6'd0};
    #1 chk("R6 base_idx", {13'd0, base_idx}, 16'd3);
  endtask

  task automatic t_call_rel(input logic [10:0] d, input logic [15:0] pc);
    int off;
    off = d[10] ? int'(d) - 2048 : int'(d);
    send({4'b0100, 1'b1, d}, pc, 3'b001, 16'h0);
    chk("R5 target", next_pc, add_off(pc, off));
    chk("R5 link_we", {15'd0, link_we}, 16'd1);
    chk("R5 link_val", link_val, pc);
  endtask

  task automatic t_call_reg;
    send({4'b0100, 1'b0, 2'b00, 3'd2, 6'd0}, 16'h3050, 3'b100, 16'h6000);
    chk("R6 target", next_pc, 16'h6000);
    chk("R6 link_we", {15'd0, link_we}, 16'd1);
    chk("R6 link_val", link_val, 16'h3050);
  endtask

  task automatic t_trap(input logic [7:0] v, input logic [15:0] pc);
    @(negedge clk);
    instr = {4'b1111, 4'b0000, v}; pc_inc = pc; instr_valid = 1'b1;
    #1;
    chk("R7 vec_rd", {15'd0, vec_rd}, 16'd1);
    chk("R7 vec_addr", {8'd0, vec_addr}, {8'd0, v});
    @(negedge clk);
    chk("R8 busy", {15'd0, busy}, 16'd1);
    chk("R8 no result yet", {15'd0, npc_valid}, 16'd0);
    // a jump offered while busy must be dropped
    instr = {4'b1100, 3'b000, 3'd1, 6'd0}; pc_inc = 16'h7777; base_val = 16'hBEEF;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R7 target", next_pc, table_word(v));
    chk("R7 link_val", link_val, pc);
    chk("R7 link_we", {15'd0, link_we}, 16'd1);
    chk("R8 busy cleared", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R8 ignored instr", {15'd0, npc_valid}, 16'd0);
  endtask

  task automatic t_other;
    send(16'h1441, 16'h3101, 3'b100, 16'h9999);
    chk("R9 target", next_pc, 16'h3101);
    chk("R9 no link", {15'd0, link_we}, 16'd0);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    instr = 16'h5000; pc_inc = 16'h0100; instr_valid = 1'b1;
    @(negedge clk);
    chk("R10 first valid", {15'd0, npc_valid}, 16'd1);
    chk("R10 first pc", next_pc, 16'h0100);
    instr = {4'b1100, 3'b000, 3'd4, 6'd0}; base_val = 16'h0A0A;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R10 second valid", {15'd0, npc_valid}, 16'd1);
    chk("R10 second pc", next_pc, 16'h0A0A);
    @(negedge clk);
    chk("R10 pulse ends", {15'd0, npc_valid}, 16'd0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_branch(3'b100, 3'b100, 9'd9, 16'h3000, 1'b1, "R2 n taken");
    t_branch(3'b010, 3'b001, 9'd9, 16'h3000, 1'b0, "R2 z vs p");
    t_branch(3'b011, 3'b001, 9'h1F0, 16'h3020, 1'b1, "R2 zp back");
    t_branch(3'b000, 3'b010, 9'd5, 16'h3000, 1'b0, "R3 mask000 z");
    t_branch(3'b000, 3'b100, 9'd5, 16'h3000, 1'b0, "R3 mask000 n");
    t_branch(3'b111, 3'b001, 9'd7, 16'h3000, 1'b1, "R3 mask111 p");
    t_branch(3'b111, 3'b100, 9'h1FE, 16'h3000, 1'b1, "R3 mask111 n");
    t_branch(3'b001, 3'b001, 9'd5, 16'hFFFF, 1'b1, "R11 wrap up");
    t_branch(3'b010, 3'b010, 9'h1FE, 16'h0001, 1'b1, "R11 wrap down");
    t_jump();
    t_base_idx();
    t_call_rel(11'd12, 16'h3000);
    t_call_rel(11'h7F0, 16'h0008);
    t_call_reg();
    t_trap(8'h25, 16'h3102);
    t_trap(8'h00, 16'hFFFF);
    t_other();
    t_b2b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule